// File: doc/BRIEF.md
# Legacy Interrupt Level-to-Pulse Merger

This block takes the four level-sensitive legacy interrupt wires of a PCIe link, INTA through INTD, and folds them onto one output. That output toward the host interrupt controller only signals with single-cycle pulses. A held level would otherwise be lost on a pulse-type line. To keep level behaviour, software writes an end-of-interrupt code into a register once it has serviced the sources. The block then looks at the inputs again and pulses once more if an enabled source is still asserted.

Software reaches the block through a plain 32-bit register port with a one-cycle registered read. That port holds a per-line enable register, a raw status register and the end-of-interrupt register. A build-time parameter selects a compatibility variant. In that variant the end-of-interrupt register is ignored, and the output pulses once for every assert edge and once for every deassert edge of an enabled line.

Top module: `intx_pulse_merge`

## Requirements
- R1: After reset the output is low, every enable bit reads as zero and no end-of-interrupt re-check is pending.
- R2: The enable register at offset 0x104 holds one bit per line at bit 22+n (n = 0..3 for INTA..INTD). Its other bits ignore writes and read as zero.
- R3: The status register at offset 0x504 shows the sampled raw level of line n at bit 22+n, whatever the enable state of that line. Its other bits read as zero.
- R4: Every output pulse lasts exactly one clock cycle.
- R5: In normal mode, a pulse goes out when the OR of the enabled, asserted lines goes from 0 to 1. The output is high in the second cycle after the input or register change.
- R6: In normal mode, enabling a line that is already asserted counts as such a 0-to-1 change and produces a pulse.
- R7: In normal mode, no further pulse goes out while the OR stays high, even when more lines assert or some deassert. Disabled lines never cause a pulse.
- R8: Writing the value 2 to the end-of-interrupt register at offset 0xC8 produces a pulse in the second cycle after the write if an enabled line is asserted, and no pulse otherwise.
- R9: End-of-interrupt codes 0, 1 and 3 are accepted and have no effect on the output. The end-of-interrupt register and unmapped offsets read as zero.
- R10: In compatibility mode, each assert edge and each deassert edge of an enabled line gives one pulse in the second cycle after the change. Edges landing in the same cycle share a single pulse, and end-of-interrupt writes have no effect.
- R11: Read data appears on the edge that samples the read enable and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intxLevel | input | 4 | Legacy interrupt levels, bit n is line n (INTA..INTD) |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 32 | Registered read data |
| irqPulse | output | 1 | Merged single-cycle interrupt pulse |

## Verification
The state that matters is the enable bits, the previous value of the merged level and the pending re-check flag. If the stored previous level is wrong, the port shows either a missing pulse or an extra one exactly two cycles after a line or enable change. If the re-check flag is lost or stuck, the end-of-interrupt write fails to pulse, or codes other than 2 make it pulse, also two cycles after the write. Enable corruption shows up on the very next read of the enable register, and in whether a later assertion fires.

// File: rtl/intx_merge_pkg.sv
package intx_merge_pkg;
  localparam int INTX_LINES = 4;

  typedef enum logic [1:0] {
    EOI_DOWNSTREAM = 2'd0,
    EOI_FN_RESET   = 2'd1,
    EOI_LEGACY     = 2'd2,
    EOI_POWER      = 2'd3
  } eoi_code_e;

  typedef struct packed {
    logic                  enableWr;
    logic [INTX_LINES-1:0] enableVal;
    logic                  eoiLegacy;
  } intx_ctrl_t;
endpackage

// File: rtl/intx_merge_ctrl.sv
module intx_merge_ctrl
  import intx_merge_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int ENABLE_OFS = 'h104,
  parameter int STATUS_OFS = 'h504,
  parameter int EOI_OFS    = 'hC8,
  parameter int FIELD_LSB  = 22
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [INTX_LINES-1:0] enableQ,
  input  logic [INTX_LINES-1:0] levelQ,
  output intx_ctrl_t            ctrl,
  output logic [DATA_W-1:0]     regRdData
);
  localparam logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(ENABLE_OFS);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] EOI_ADDR    = ADDR_W'(EOI_OFS);
  localparam logic [DATA_W-1:0] LEGACY_CODE = DATA_W'(EOI_LEGACY);

  logic hitEnable, hitStatus, hitEoi;
  logic eoiLegacyWr, eoiPendQ;
  logic [DATA_W-1:0] rdNext;

  function automatic logic [DATA_W-1:0] placeField(input logic [INTX_LINES-1:0] v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[FIELD_LSB +: INTX_LINES] = v;
    return w;
  endfunction

  assign hitEnable   = (regAddr == ENABLE_ADDR);
  assign hitStatus   = (regAddr == STATUS_ADDR);
  assign hitEoi      = (regAddr == EOI_ADDR);
  assign eoiLegacyWr = regWrEn && hitEoi && (regWrData == LEGACY_CODE);

  // the re-check request is registered so it meets the freshly sampled levels
  always_ff @(posedge clk) begin
    if (!rstN) eoiPendQ <= 1'b0;
    else       eoiPendQ <= eoiLegacyWr;
  end

  always_comb begin
    ctrl.enableWr  = regWrEn && hitEnable;
    ctrl.enableVal = regWrData[FIELD_LSB +: INTX_LINES];
    ctrl.eoiLegacy = eoiPendQ;
  end

  always_comb begin
    rdNext = '0;
    if (hitEnable)      rdNext = placeField(enableQ);
    else if (hitStatus) rdNext = placeField(levelQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdNext;
  end

  // R9: the end-of-interrupt register never returns data
  p_eoi_reads_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && hitEoi) |=> (regRdData == '0));

  // R9: codes other than legacy leave no re-check behind
  p_other_codes_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && hitEoi && (regWrData != LEGACY_CODE)) |=> !ctrl.eoiLegacy);

  // R11: without a read strobe the read data holds
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdEn && $past(rstN)) |=> $stable(regRdData));
endmodule

// File: rtl/intx_merge_datapath.sv
module intx_merge_datapath
  import intx_merge_pkg::*;
#(
  parameter bit COMPAT_MODE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [INTX_LINES-1:0] intxLevel,
  input  intx_ctrl_t            ctrl,
  output logic [INTX_LINES-1:0] enableQ,
  output logic [INTX_LINES-1:0] levelQ,
  output logic                  irqPulse
);
  logic fireReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ  <= '0;
      enableQ <= '0;
    end else begin
      levelQ <= intxLevel;
      if (ctrl.enableWr) enableQ <= ctrl.enableVal;
    end
  end

  // a request arriving while a pulse is out is absorbed by that pulse
  always_ff @(posedge clk) begin
    if (!rstN) irqPulse <= 1'b0;
    else       irqPulse <= fireReq && !irqPulse;
  end

  generate
    if (COMPAT_MODE == 1'b0) begin : g_level
      logic activeNow, activePrev;
      assign activeNow = |(levelQ & enableQ);

      always_ff @(posedge clk) begin
        if (!rstN) activePrev <= 1'b0;
        else       activePrev <= activeNow;
      end

      assign fireReq = (activeNow && !activePrev) || (ctrl.eoiLegacy && activeNow);

      // R5 and R6: a rise of the merged level is announced next cycle
      p_rise_fires_r5: assert property (@(posedge clk) disable iff (!rstN)
        ($rose(activeNow) && !irqPulse) |=> irqPulse);

      // R7: a steady merged level without a re-check stays silent
      p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
        (activePrev && !ctrl.eoiLegacy) |=> !irqPulse);

      // R8: a legacy re-check with a live source fires
      p_eoi_fires_r8: assert property (@(posedge clk) disable iff (!rstN)
        (ctrl.eoiLegacy && activeNow && !irqPulse) |=> irqPulse);
    end else begin : g_edge
      logic [INTX_LINES-1:0] levelPrev;
      logic [INTX_LINES-1:0] edgeHit;

      always_ff @(posedge clk) begin
        if (!rstN) levelPrev <= '0;
        else       levelPrev <= levelQ;
      end

      assign edgeHit = (levelQ ^ levelPrev) & enableQ;
      assign fireReq = |edgeHit;

      // R10: no edge means no pulse, end-of-interrupt notwithstanding
      p_no_edge_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
        (levelQ == levelPrev) |=> !irqPulse);

      // R10: an enabled edge fires
      p_edge_fires_r10: assert property (@(posedge clk) disable iff (!rstN)
        (((levelQ ^ levelPrev) & enableQ) != '0 && !irqPulse) |=> irqPulse);
    end
  endgenerate

  // R4: pulses are one cycle wide
  p_single_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);
endmodule

// File: rtl/intx_pulse_merge.sv
module intx_pulse_merge
  import intx_merge_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int ENABLE_OFS  = 'h104,
  parameter int STATUS_OFS  = 'h504,
  parameter int EOI_OFS     = 'hC8,
  parameter int FIELD_LSB   = 22,
  parameter bit COMPAT_MODE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [INTX_LINES-1:0] intxLevel,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  output logic [DATA_W-1:0]     regRdData,
  output logic                  irqPulse
);
  intx_ctrl_t            ctrl;
  logic [INTX_LINES-1:0] enableQ;
  logic [INTX_LINES-1:0] levelQ;

  intx_merge_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENABLE_OFS(ENABLE_OFS),
    .STATUS_OFS(STATUS_OFS), .EOI_OFS(EOI_OFS), .FIELD_LSB(FIELD_LSB)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .enableQ(enableQ), .levelQ(levelQ),
    .ctrl(ctrl), .regRdData(regRdData)
  );

  intx_merge_datapath #(.COMPAT_MODE(COMPAT_MODE)) u_dp (
    .clk(clk), .rstN(rstN), .intxLevel(intxLevel), .ctrl(ctrl),
    .enableQ(enableQ), .levelQ(levelQ), .irqPulse(irqPulse)
  );
endmodule

// File: tb/intx_pulse_merge_test.sv
module intx_pulse_merge_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_EN  = 12'h104;
  localparam logic [11:0] A_ST  = 12'h504;
  localparam logic [11:0] A_EOI = 12'h0C8;

  logic clk = 1'b0;
  logic rstN;
  logic [3:0] intxLevel;
  logic [11:0] regAddr;
  logic [31:0] regWrData;
  logic regWrEn, regRdEn;
  logic [31:0] rdNorm, rdCompat;
  logic irqNorm, irqCompat;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intx_pulse_merge uut (
    .clk(clk), .rstN(rstN), .intxLevel(intxLevel), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regRdData(rdNorm), .irqPulse(irqNorm));

  intx_pulse_merge #(.COMPAT_MODE(1'b1)) uutCompat (
    .clk(clk), .rstN(rstN), .intxLevel(intxLevel), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regRdData(rdCompat), .irqPulse(irqCompat));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = rdNorm;
  endtask

  // called one edge after the change was sampled; expects output on the next edge only
  task automatic watch(input string req, input bit compat, input bit expHigh);
    stepN(1);
    check(req, compat ? irqCompat : irqNorm, expHigh);
    stepN(1);
    check({req, " width"}, compat ? irqCompat : irqNorm, 1'b0);
  endtask

  task automatic setLevel(input logic [3:0] v);
    intxLevel = v;
    stepN(1);
  endtask

  task automatic testReset;
    logic [31:0] d;
    check("R1 irq in reset", irqNorm, 1'b0);
    check("R1 compat irq in reset", irqCompat, 1'b0);
    rstN = 1'b1;
    stepN(1);
    regRead(A_EN, d);
    check("R1 enable after reset", d, 32'h0);
    // no pending re-check: a live but disabled line stays silent
    setLevel(4'b0001);
    watch("R1 no pending re-check", 1'b0, 1'b0);
    setLevel(4'b0000);
    stepN(2);
  endtask

  task automatic testRegisters;
    logic [31:0] d;
    regWrite(A_EN, 32'hFFFF_FFFF);
    regRead(A_EN, d);
    check("R2 enable field only", d, 32'h03C0_0000);
    check("R11 compat instance read", rdCompat, 32'h03C0_0000);
    regWrite(A_EN, 32'h0040_0000);
    regRead(A_EN, d);
    check("R2 enable INTA only", d, 32'h0040_0000);
    regRead(12'h200, d);
    check("R9 unmapped read zero", d, 32'h0);
    stepN(2);
    check("R11 read data holds", rdNorm, 32'h0);
    // INTA enabled; INTB and INTD raw levels must still show
    setLevel(4'b1010);
    check("R7 disabled lines quiet", irqNorm, 1'b0);
    stepN(1);
    check("R7 disabled lines quiet late", irqNorm, 1'b0);
    regRead(A_ST, d);
    check("R3 raw status", d, 32'h0280_0000);
    setLevel(4'b0101);
    stepN(1);
    regRead(A_ST, d);
    check("R3 status A and C", d, 32'h0140_0000);
    setLevel(4'b0000);
    regWrite(A_EN, 32'h0);
    stepN(3);
  endtask

  task automatic testNormal;
    logic [31:0] d;
    regWrite(A_EN, 32'h03C0_0000);
    stepN(3);
    check("R5 idle before assert", irqNorm, 1'b0);
    setLevel(4'b0010);
    watch("R5 INTB rise pulse", 1'b0, 1'b1);
    setLevel(4'b0011);
    watch("R7 second line silent", 1'b0, 1'b0);
    stepN(3);
    check("R7 still silent", irqNorm, 1'b0);
    regWrite(A_EOI, 32'd2);
    watch("R8 eoi re-fires", 1'b0, 1'b1);
    regWrite(A_EOI, 32'd0);
    watch("R9 eoi code 0", 1'b0, 1'b0);
    regWrite(A_EOI, 32'd1);
    watch("R9 eoi code 1", 1'b0, 1'b0);
    regWrite(A_EOI, 32'd3);
    watch("R9 eoi code 3", 1'b0, 1'b0);
    regRead(A_EOI, d);
    check("R9 eoi reads zero", d, 32'h0);
    setLevel(4'b0001);
    watch("R7 partial deassert silent", 1'b0, 1'b0);
    regWrite(A_EOI, 32'd2);
    watch("R8 eoi with INTA left", 1'b0, 1'b1);
    setLevel(4'b0000);
    stepN(2);
    regWrite(A_EOI, 32'd2);
    watch("R8 eoi with nothing pending", 1'b0, 1'b0);
    setLevel(4'b0100);
    watch("R5 re-rise after idle", 1'b0, 1'b1);
    setLevel(4'b0000);
    stepN(3);
  endtask

  task automatic testEnableLive;
    regWrite(A_EN, 32'h0);
    setLevel(4'b1000);
    stepN(3);
    check("R6 disabled INTD quiet", irqNorm, 1'b0);
    regWrite(A_EN, 32'h0200_0000);
    watch("R6 enable live INTD", 1'b0, 1'b1);
    setLevel(4'b0000);
    stepN(3);
  endtask

  task automatic testCompat;
    regWrite(A_EN, 32'h03C0_0000);
    stepN(3);
    check("R10 compat idle", irqCompat, 1'b0);
    setLevel(4'b0100);
    watch("R10 compat assert pulse", 1'b1, 1'b1);
    regWrite(A_EOI, 32'd2);
    watch("R10 compat eoi ignored", 1'b1, 1'b0);
    setLevel(4'b0000);
    watch("R10 compat deassert pulse", 1'b1, 1'b1);
    setLevel(4'b0011);
    watch("R10 compat merged edges", 1'b1, 1'b1);
    stepN(1);
    check("R4 compat single pulse", irqCompat, 1'b0);
    setLevel(4'b0000);
    watch("R10 compat merged release", 1'b1, 1'b1);
    regWrite(A_EN, 32'h0040_0000);
    setLevel(4'b1000);
    watch("R10 compat disabled edge", 1'b1, 1'b0);
    setLevel(4'b0000);
    stepN(2);
  endtask

  initial begin
    rstN = 1'b0; intxLevel = '0; regAddr = '0; regWrData = '0;
    regWrEn = 1'b0; regRdEn = 1'b0;
    stepN(4);
    testReset();
    testRegisters();
    testNormal();
    testEnableLive();
    testCompat();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule